// File: doc/BRIEF.md
# Auto-Increment Word Program Sequencer

This block writes a run of bytes into a serial flash that programs two bytes at a time through an auto-address-increment mode rather than through page programs. A request gives a start address and a byte count. The bytes themselves arrive on a valid/ready byte stream. The block emits a sequence of command frames to a separate serial shifter. Each frame carries an opcode, an optional address, and zero to two data bytes. The shifter answers status-read frames with the device's busy flag.

An odd start address is handled first with a single-byte program. The word-aligned middle is then sent as a chain of two-byte auto-increment frames. Only the first frame in the chain carries the address. A write disable closes the chain. A last byte that has no partner is programmed on its own and is followed by another write disable. After each program frame, and after the write disable that closes the chain, the block polls status until the device reports idle. A device that stays busy too long aborts the run, which is then reported with an error flag.

Top module: `aai_prog_seq`

## Requirements
- R1: After reset the block is idle. `busy`, `done`, `error`, `cmd_valid` and `in_ready` are low, and `wr_count` is zero.
- R2: With an odd start address and a non-zero length, the first frames are write enable (0x06) and then byte program (0x02). The byte program has `cmd_addr_en`=1, the start address, `cmd_nbytes`=1, and the first stream byte in `cmd_d0`.
- R3: Two or more bytes left at a word-aligned address produce a single write enable (0x06) and then auto-increment frames (0xAD), each with `cmd_nbytes`=2. Only the first 0xAD frame has `cmd_addr_en`=1 and an address. The earlier stream byte goes in `cmd_d0` and the later one in `cmd_d1`.
- R4: Each accepted program frame (0x02 or 0xAD), and the write disable that ends the 0xAD chain, is followed by status-read frames (0x05). Status reads repeat until a reply arrives with `sts_wip`=0. Only then does the next step begin.
- R5: Once fewer than two bytes remain after the 0xAD chain, the block sends write disable (0x04) and waits for ready.
- R6: A single remaining byte after the chain or after the head byte gets write enable, byte program (0x02) at the address of that byte, and then write disable (0x04).
- R7: `wr_count` rises by 1 per accepted 0x02 frame and by 2 per accepted 0xAD frame. It equals the requested length at `done` in a run without error.
- R8: A frame stays unchanged while `cmd_ready` is low. Stream bytes are taken only while `in_ready` is high, and exactly the requested number of bytes are taken, in order.
- R9: A run aborts after `MAX_POLLS` consecutive busy replies to status reads. The block then sends one write disable (0x04) and no other program frame, and pulses `done` together with `error`.
- R10: A zero-length request emits no frames and pulses `done` one cycle after it is accepted.
- R11: A `start` that arrives while the block is busy is ignored. The running sequence is unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Request pulse, accepted when idle |
| start_addr | input | AW | First byte address |
| length | input | LW | Number of bytes to write |
| busy | output | 1 | A run is in progress |
| done | output | 1 | One-cycle end-of-run pulse |
| error | output | 1 | High with `done` when the run aborted |
| wr_count | output | LW | Bytes handed to program frames so far |
| in_valid | input | 1 | Stream byte available |
| in_data | input | 8 | Stream byte |
| in_ready | output | 1 | Block takes the stream byte |
| cmd_valid | output | 1 | Frame offered to the shifter |
| cmd_ready | input | 1 | Shifter accepts the frame |
| cmd_op | output | 8 | Frame opcode |
| cmd_addr_en | output | 1 | Frame carries an address |
| cmd_addr | output | AW | Frame address |
| cmd_nbytes | output | 2 | Data bytes in the frame (0 to 2) |
| cmd_d0 | output | 8 | First data byte |
| cmd_d1 | output | 8 | Second data byte |
| sts_valid | input | 1 | Status reply present |
| sts_wip | input | 1 | Device busy flag from the status reply |

## Verification
The assertions check on every cycle that frames hold steady under back-pressure. They also check that a status read follows each program frame and that only the first 0xAD frame of a run carries an address. Further checks confirm that the byte counter never passes the requested length and that no program frame appears after an abort. The full frame order for odd and even starts, the lone trailing byte, and zero length can only be seen across whole scenarios. The same holds for the matching of stream bytes to frame slots, the exact poll count before a timeout, and a second `start` being ignored. The bench covers these by comparing the recorded frame log with a list it builds itself.

// File: rtl/aai_pkg.sv
package aai_pkg;

    localparam logic [7:0] OP_WREN = 8'h06;
    localparam logic [7:0] OP_WRDI = 8'h04;
    localparam logic [7:0] OP_BP   = 8'h02;
    localparam logic [7:0] OP_AAI  = 8'hAD;
    localparam logic [7:0] OP_RDSR = 8'h05;

    typedef enum logic [2:0] {
        ST_IDLE, ST_WREN, ST_FETCH, ST_DATA,
        ST_PREQ, ST_PWAIT, ST_WRDI, ST_FIN
    } seq_state_e;

    // which part of the byte range the sequencer is working on
    typedef enum logic [2:0] {
        PH_HEAD, PH_BODY, PH_EXIT, PH_TAIL, PH_ABORT
    } seq_phase_e;

    typedef struct packed {
        logic       valid;
        logic [7:0] op;
        logic       addr_en;
        logic [1:0] nbytes;
    } frame_t;

    function automatic logic [1:0] bytes_for(seq_phase_e p);
        return (p == PH_BODY) ? 2'd2 : 2'd1;
    endfunction

    function automatic logic [7:0] prog_opcode(seq_phase_e p);
        return (p == PH_BODY) ? OP_AAI : OP_BP;
    endfunction

endpackage

// File: rtl/aai_poll_guard.sv
module aai_poll_guard #(
    parameter int MAX_POLLS = 4096
) (
    input  logic clk,
    input  logic rst,
    input  logic clr,
    input  logic bump,
    output logic expired
);
    localparam int CW = $clog2(MAX_POLLS + 1);

    logic [CW-1:0] busy_cnt;

    // expired means this busy reply is the last one allowed
    assign expired = (busy_cnt == CW'(MAX_POLLS - 1));

    always_ff @(posedge clk) begin
        if (rst || clr)
            busy_cnt <= '0;
        else if (bump && !expired)
            busy_cnt <= busy_cnt + 1'b1;
    end

endmodule

// File: rtl/aai_seq_ctrl.sv
module aai_seq_ctrl
    import aai_pkg::*;
#(
    parameter int AW = 24,
    parameter int LW = 16
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          start,
    input  logic [AW-1:0] start_addr,
    input  logic [LW-1:0] length,
    output logic          busy,
    output logic          done,
    output logic          error,
    output logic [LW-1:0] wr_count,
    input  logic          in_valid,
    input  logic [7:0]    in_data,
    output logic          in_ready,
    output logic          cmd_valid,
    input  logic          cmd_ready,
    output logic [7:0]    cmd_op,
    output logic          cmd_addr_en,
    output logic [AW-1:0] cmd_addr,
    output logic [1:0]    cmd_nbytes,
    output logic [7:0]    cmd_d0,
    output logic [7:0]    cmd_d1,
    input  logic          sts_valid,
    input  logic          sts_wip,
    input  logic          poll_expired,
    output logic          poll_clr,
    output logic          poll_bump
);
    seq_state_e    st;
    seq_phase_e    ph;
    logic          first_q, got_q, err_q;
    logic [AW-1:0] addr_q;
    logic [LW-1:0] rem_q, cnt_q, len_q;
    logic [7:0]    d0_q, d1_q;
    logic [1:0]    need;
    frame_t        frm;

    assign need = bytes_for(ph);

    always_comb begin
        frm = '{valid: 1'b0, op: OP_RDSR, addr_en: 1'b0, nbytes: 2'd0};
        case (st)
            ST_WREN: begin frm.valid = 1'b1; frm.op = OP_WREN; end
            ST_WRDI: begin frm.valid = 1'b1; frm.op = OP_WRDI; end
            ST_PREQ: begin frm.valid = 1'b1; frm.op = OP_RDSR; end
            ST_DATA: begin
                frm.valid   = 1'b1;
                frm.op      = prog_opcode(ph);
                frm.addr_en = (ph != PH_BODY) || first_q;
                frm.nbytes  = need;
            end
            default: ;
        endcase
    end

    assign cmd_valid   = frm.valid;
    assign cmd_op      = frm.op;
    assign cmd_addr_en = frm.addr_en;
    assign cmd_nbytes  = frm.nbytes;
    assign cmd_addr    = addr_q;
    assign cmd_d0      = d0_q;
    assign cmd_d1      = d1_q;
    assign in_ready    = (st == ST_FETCH);
    assign busy        = (st != ST_IDLE);
    assign done        = (st == ST_FIN);
    assign error       = (st == ST_FIN) && err_q;
    assign wr_count    = cnt_q;
    assign poll_bump   = (st == ST_PWAIT) && sts_valid && sts_wip;
    assign poll_clr    = cmd_ready && ((st == ST_DATA) || (st == ST_WRDI));

    always_ff @(posedge clk) begin
        if (rst) begin
            st      <= ST_IDLE;
            ph      <= PH_HEAD;
            first_q <= 1'b0;
            got_q   <= 1'b0;
            err_q   <= 1'b0;
            addr_q  <= '0;
            rem_q   <= '0;
            cnt_q   <= '0;
            len_q   <= '0;
            d0_q    <= '0;
            d1_q    <= '0;
        end else begin
            case (st)
                ST_IDLE: if (start) begin
                    addr_q  <= start_addr;
                    rem_q   <= length;
                    len_q   <= length;
                    cnt_q   <= '0;
                    err_q   <= 1'b0;
                    got_q   <= 1'b0;
                    first_q <= 1'b0;
                    if (length == '0) begin
                        st <= ST_FIN;
                    end else if (start_addr[0]) begin
                        ph <= PH_HEAD; st <= ST_WREN;
                    end else if (length >= LW'(2)) begin
                        ph <= PH_BODY; first_q <= 1'b1; st <= ST_WREN;
                    end else begin
                        ph <= PH_TAIL; st <= ST_WREN;
                    end
                end
                ST_WREN: if (cmd_ready) st <= ST_FETCH;
                ST_FETCH: if (in_valid) begin
                    if (!got_q) d0_q <= in_data;
                    else        d1_q <= in_data;
                    if (need == 2'd2 && !got_q) begin
                        got_q <= 1'b1;
                    end else begin
                        got_q <= 1'b0;
                        st    <= ST_DATA;
                    end
                end
                ST_DATA: if (cmd_ready) begin
                    cnt_q   <= cnt_q + LW'(need);
                    rem_q   <= rem_q - LW'(need);
                    addr_q  <= addr_q + AW'(need);
                    first_q <= 1'b0;
                    st      <= ST_PREQ;
                end
                ST_PREQ: if (cmd_ready) st <= ST_PWAIT;
                ST_PWAIT: if (sts_valid) begin
                    if (!sts_wip) begin
                        case (ph)
                            PH_HEAD: begin
                                if (rem_q >= LW'(2)) begin
                                    ph <= PH_BODY; first_q <= 1'b1; st <= ST_WREN;
                                end else if (rem_q == LW'(1)) begin
                                    ph <= PH_TAIL; st <= ST_WREN;
                                end else begin
                                    st <= ST_FIN;
                                end
                            end
                            PH_BODY: begin
                                if (rem_q >= LW'(2)) st <= ST_FETCH;
                                else begin ph <= PH_EXIT; st <= ST_WRDI; end
                            end
                            PH_EXIT: begin
                                if (rem_q == LW'(1)) begin ph <= PH_TAIL; st <= ST_WREN; end
                                else st <= ST_FIN;
                            end
                            PH_TAIL: st <= ST_WRDI;
                            default: st <= ST_FIN;
                        endcase
                    end else if (poll_expired) begin
                        ph    <= PH_ABORT;
                        err_q <= 1'b1;
                        st    <= ST_WRDI;
                    end else begin
                        st <= ST_PREQ;
                    end
                end
                ST_WRDI: if (cmd_ready) st <= (ph == PH_EXIT) ? ST_PREQ : ST_FIN;
                ST_FIN: st <= ST_IDLE;
                default: st <= ST_IDLE;
            endcase
        end
    end

    // R8: an offered frame does not change until it is taken
    p_frame_hold_r8: assert property (@(posedge clk) disable iff (rst)
        cmd_valid && !cmd_ready |=> cmd_valid && $stable(cmd_op) && $stable(cmd_addr_en)
            && $stable(cmd_addr) && $stable(cmd_d0) && $stable(cmd_d1) && $stable(cmd_nbytes));

    // R4: a status read is offered right after a program frame is taken
    p_poll_after_prog_r4: assert property (@(posedge clk) disable iff (rst)
        cmd_valid && cmd_ready && (cmd_op == OP_BP || cmd_op == OP_AAI)
            |=> cmd_valid && cmd_op == OP_RDSR);

    // R3: the addressed auto-increment frame comes before any word is written
    p_aai_addr_first_r3: assert property (@(posedge clk) disable iff (rst)
        cmd_valid && cmd_op == OP_AAI && cmd_addr_en |-> cnt_q <= LW'(1));

    // R3: later auto-increment frames come after at least one word
    p_aai_noaddr_later_r3: assert property (@(posedge clk) disable iff (rst)
        cmd_valid && cmd_op == OP_AAI && !cmd_addr_en |-> cnt_q >= LW'(2));

    // R7: the written count never passes the requested length
    p_count_bound_r7: assert property (@(posedge clk) disable iff (rst)
        busy |-> cnt_q <= len_q);

    // R9: once aborted, no program frame is offered
    p_no_prog_after_abort_r9: assert property (@(posedge clk) disable iff (rst)
        err_q |-> !(cmd_valid && (cmd_op == OP_BP || cmd_op == OP_AAI)));

    // R10: done is a single pulse that returns the block to idle
    p_done_then_idle_r10: assert property (@(posedge clk) disable iff (rst)
        done |=> !busy && !done);

endmodule

// File: rtl/aai_prog_seq.sv
module aai_prog_seq #(
    parameter int AW        = 24,
    parameter int LW        = 16,
    parameter int MAX_POLLS = 4096
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          start,
    input  logic [AW-1:0] start_addr,
    input  logic [LW-1:0] length,
    output logic          busy,
    output logic          done,
    output logic          error,
    output logic [LW-1:0] wr_count,
    input  logic          in_valid,
    input  logic [7:0]    in_data,
    output logic          in_ready,
    output logic          cmd_valid,
    input  logic          cmd_ready,
    output logic [7:0]    cmd_op,
    output logic          cmd_addr_en,
    output logic [AW-1:0] cmd_addr,
    output logic [1:0]    cmd_nbytes,
    output logic [7:0]    cmd_d0,
    output logic [7:0]    cmd_d1,
    input  logic          sts_valid,
    input  logic          sts_wip
);
    logic poll_expired, poll_clr, poll_bump;

    aai_seq_ctrl #(.AW(AW), .LW(LW)) u_ctrl (
        .clk(clk), .rst(rst), .start(start), .start_addr(start_addr), .length(length),
        .busy(busy), .done(done), .error(error), .wr_count(wr_count),
        .in_valid(in_valid), .in_data(in_data), .in_ready(in_ready),
        .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_op(cmd_op),
        .cmd_addr_en(cmd_addr_en), .cmd_addr(cmd_addr), .cmd_nbytes(cmd_nbytes),
        .cmd_d0(cmd_d0), .cmd_d1(cmd_d1), .sts_valid(sts_valid), .sts_wip(sts_wip),
        .poll_expired(poll_expired), .poll_clr(poll_clr), .poll_bump(poll_bump)
    );

    aai_poll_guard #(.MAX_POLLS(MAX_POLLS)) u_guard (
        .clk(clk), .rst(rst), .clr(poll_clr), .bump(poll_bump), .expired(poll_expired)
    );

endmodule

// File: tb/aai_prog_seq_test.sv
module aai_prog_seq_test;
    localparam int AW = 24;
    localparam int LW = 16;
    localparam int MP = 6;

    logic clk = 1'b0;
    always #4 clk = ~clk;

    logic          rst, start, busy, done, error, in_valid, in_ready;
    logic [AW-1:0] start_addr, cmd_addr;
    logic [LW-1:0] length, wr_count;
    logic [7:0]    in_data, cmd_op, cmd_d0, cmd_d1;
    logic          cmd_valid, cmd_ready, cmd_addr_en, sts_valid, sts_wip;
    logic [1:0]    cmd_nbytes;

    aai_prog_seq #(.AW(AW), .LW(LW), .MAX_POLLS(MP)) uut (
        .clk(clk), .rst(rst), .start(start), .start_addr(start_addr), .length(length),
        .busy(busy), .done(done), .error(error), .wr_count(wr_count),
        .in_valid(in_valid), .in_data(in_data), .in_ready(in_ready),
        .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_op(cmd_op),
        .cmd_addr_en(cmd_addr_en), .cmd_addr(cmd_addr), .cmd_nbytes(cmd_nbytes),
        .cmd_d0(cmd_d0), .cmd_d1(cmd_d1), .sts_valid(sts_valid), .sts_wip(sts_wip)
    );

    int n_chk = 0;
    int n_fail = 0;
    int salt = 0;
    int idx = 0;
    bit take = 0;
    bit stuck = 0;
    int busy_left = 0;
    int sts_cd = 0;
    int rdy_replies = 0;
    int busy_replies = 0;

    logic [7:0]    l_op[64], l_d0[64], l_d1[64];
    logic          l_ae[64];
    logic [AW-1:0] l_addr[64];
    int            l_nb[64];
    int            l_n = 0;

    logic [7:0]    e_op[64], e_d0[64], e_d1[64];
    logic          e_ae[64];
    logic [AW-1:0] e_addr[64];
    int            e_nb[64];
    string         e_tag[64];
    int            e_n, e_waits, e_cnt;

    function automatic logic [7:0] byte_at(int k);
        return 8'(k * 37 + salt);
    endfunction

    task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic push(input logic [7:0] op, input logic ae, input logic [AW-1:0] a,
                        input int nb, input logic [7:0] d0, input logic [7:0] d1, input string tag);
        e_op[e_n] = op; e_ae[e_n] = ae; e_addr[e_n] = a; e_nb[e_n] = nb;
        e_d0[e_n] = d0; e_d1[e_n] = d1; e_tag[e_n] = tag;
        e_n++;
    endtask

    // expected frame list (status reads excluded) from the requirements
    task automatic build(input logic [AW-1:0] addr, input int len, input bit stk);
        logic [AW-1:0] a = addr;
        int rem = len;
        int k = 0;
        bit first;
        e_n = 0; e_waits = 0; e_cnt = 0;
        if (rem == 0) return;
        if (a[0]) begin
            push(8'h06, 0, 0, 0, 0, 0, "R2");
            push(8'h02, 1, a, 1, byte_at(0), 0, "R2");
            k = 1; a = a + 1; rem--; e_waits++;
            if (stk) begin push(8'h04, 0, 0, 0, 0, 0, "R9"); e_cnt = k; return; end
        end
        if (rem >= 2) begin
            push(8'h06, 0, 0, 0, 0, 0, "R3");
            first = 1;
            while (rem >= 2) begin
                push(8'hAD, first, a, 2, byte_at(k), byte_at(k + 1), "R3");
                first = 0; k += 2; a = a + 2; rem -= 2; e_waits++;
                if (stk) begin push(8'h04, 0, 0, 0, 0, 0, "R9"); e_cnt = k; return; end
            end
            push(8'h04, 0, 0, 0, 0, 0, "R5");
            e_waits++;
        end
        if (rem == 1) begin
            push(8'h06, 0, 0, 0, 0, 0, "R6");
            push(8'h02, 1, a, 1, byte_at(k), 0, "R6");
            k++; e_waits++;
            if (stk) begin push(8'h04, 0, 0, 0, 0, 0, "R9"); e_cnt = k; return; end
            push(8'h04, 0, 0, 0, 0, 0, "R6");
        end
        e_cnt = k;
    endtask

    // shifter model: random acceptance, frame log, status replies
    initial begin
        cmd_ready = 0; sts_valid = 0; sts_wip = 0;
        forever begin
            @(negedge clk);
            sts_valid = 0;
            if (sts_cd > 0) begin
                sts_cd--;
                if (sts_cd == 0) begin
                    sts_valid = 1;
                    sts_wip = stuck || (busy_left > 0);
                    if (sts_wip) begin
                        busy_replies++;
                        if (!stuck) busy_left--;
                    end else begin
                        rdy_replies++;
                        busy_left = $urandom_range(0, 2);
                    end
                end
            end
            cmd_ready = ($urandom_range(0, 3) != 0);
            if (cmd_valid && cmd_ready) begin
                if (cmd_op == 8'h05) sts_cd = $urandom_range(1, 3);
                else if (l_n < 64) begin
                    l_op[l_n] = cmd_op; l_ae[l_n] = cmd_addr_en; l_addr[l_n] = cmd_addr;
                    l_nb[l_n] = int'(cmd_nbytes); l_d0[l_n] = cmd_d0; l_d1[l_n] = cmd_d1;
                    l_n++;
                end
            end
        end
    end

    // byte stream source with random gaps
    initial begin
        in_valid = 0; in_data = 0;
        forever begin
            @(negedge clk);
            if (take) idx++;
            in_valid = ($urandom_range(0, 2) != 0);
            in_data = byte_at(idx);
            take = in_valid && in_ready;
        end
    end

    task automatic run(input logic [AW-1:0] addr, input int len, input bit stk, input bit intrude);
        int cyc = 0;
        int lim;
        string ctag;
        salt = int'($urandom_range(0, 255));
        build(addr, len, stk);
        l_n = 0; rdy_replies = 0; busy_replies = 0; idx = 0;
        stuck = stk; busy_left = $urandom_range(0, 2);
        @(negedge clk);
        start = 1; start_addr = addr; length = LW'(len);
        @(negedge clk);
        start = 0;
        while (!done && cyc < 3000) begin
            @(negedge clk);
            cyc++;
            if (intrude && cyc == 5) begin
                start = 1; start_addr = ~addr; length = LW'(len + 3);
            end else start = 0;
        end
        chk(cyc < 3000, "R7 run finished", cyc, 3000);
        chk(error == stk, stk ? "R9 error with done" : "R7 no error", error, stk);
        chk(wr_count == LW'(e_cnt), stk ? "R9 count at abort" : "R7 count at done", wr_count, e_cnt);
        repeat (10) @(negedge clk);
        chk(!busy && !in_ready && !cmd_valid, "R10 idle after done", busy, 0);
        ctag = (len == 0) ? "R10 no frames" : (intrude ? "R11 frames unchanged" : "R8 frame count");
        chk(l_n == e_n, ctag, l_n, e_n);
        lim = (l_n < e_n) ? l_n : e_n;
        for (int i = 0; i < lim; i++) begin
            chk(l_op[i] == e_op[i], {e_tag[i], " opcode"}, l_op[i], e_op[i]);
            chk(l_ae[i] == e_ae[i], {e_tag[i], " address flag"}, l_ae[i], e_ae[i]);
            if (e_ae[i]) chk(l_addr[i] == e_addr[i], {e_tag[i], " address"}, l_addr[i], e_addr[i]);
            chk(l_nb[i] == e_nb[i], {e_tag[i], " byte count"}, l_nb[i], e_nb[i]);
            if (e_nb[i] >= 1) chk(l_d0[i] == e_d0[i], {e_tag[i], " first byte R8"}, l_d0[i], e_d0[i]);
            if (e_nb[i] == 2) chk(l_d1[i] == e_d1[i], {e_tag[i], " second byte R8"}, l_d1[i], e_d1[i]);
        end
        chk(idx == e_cnt, "R8 bytes consumed", idx, e_cnt);
        if (stk) chk(busy_replies == MP, "R9 busy polls before abort", busy_replies, MP);
        else     chk(rdy_replies == e_waits, "R4 ready waits", rdy_replies, e_waits);
    endtask

    initial begin
        void'($urandom(32'd2024));
        rst = 1; start = 0; start_addr = '0; length = '0;
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);
        chk(!busy && !done && !error && !cmd_valid && !in_ready, "R1 reset outputs idle", busy, 0);
        chk(wr_count == '0, "R1 reset count", wr_count, 0);

        run(24'h000100, 6, 0, 0);   // even start, body only
        run(24'h000201, 5, 0, 0);   // odd head + body
        run(24'h000301, 6, 0, 0);   // head + body + tail
        run(24'h000401, 1, 0, 0);   // head only
        run(24'h000500, 1, 0, 0);   // lone even byte
        run(24'h000601, 2, 0, 0);   // head + tail
        run(24'h000700, 2, 0, 0);   // one word
        run(24'h000800, 0, 0, 0);   // zero length
        run(24'h000900, 7, 0, 1);   // start while busy
        run(24'h000A00, 4, 1, 0);   // timeout in body
        run(24'h000B01, 3, 1, 0);   // timeout at head
        for (int s = 0; s < 25; s++)
            run(AW'($urandom), int'($urandom_range(0, 11)), 0, 0);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", 150000, 0);
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule